// File: doc/BRIEF.md
# Frequency Lock Detector

This block decides whether a recovered clock has reached frequency lock with a reference clock. Both clocks reach it as single-cycle edge strobes in the system clock domain. Recovered-clock strobes pass through a divider whose ratio depends on the selected line rate, so at the correct frequency the divided count matches the reference count. Over a window of a fixed number of reference edges, the block counts the divided edges. When the window closes, it turns the count error into parts per million of the window and compares it with a programmable limit. Hysteresis sets the limit for gaining lock below the limit for losing it.

The block drives a loss-of-lock alarm. While lock is missing, it also sends the loop a periodic single-cycle reacquisition request. A power-down/calibration suppress input has the highest priority and holds the alarm low. A missing reference comes next and forces the alarm high, because the lock state cannot be known. Both conditions clear the lock state and restart the measurement.

Top module: `freq_lock_detector`

## Requirements
- R1: The recovered strobes are divided by DIV_FAST (default 4) when `rate_sel` is 0 and by DIV_SLOW (default 1) when `rate_sel` is 1. At zero frequency error, the divided count per window equals WIN_REF.
- R2: A measurement window closes on the WIN_REF-th reference strobe that arrives while neither hold condition is present. The lock state changes only at a window close.
- R3: A locked detector becomes unlocked at a close where dev*1000000 > loss_ppm*WIN_REF. Here dev is the absolute difference between the divided count and WIN_REF.
- R4: An unlocked detector becomes locked at a close where dev*1000000 <= (loss_ppm-HYST_PPM)*WIN_REF. The value in parentheses floors at 0. A deviation that falls between the two limits leaves the state unchanged.
- R5: With the reference valid and no suppress, `lol` is 1 when unlocked and 0 when locked. It takes its new value no later than the second clock edge after the close.
- R6: `reacq` is a one-cycle pulse. It is issued on the REACQ_K-th consecutive window close that ends unlocked, and the run count then starts again. A locked close clears the run count, and so does either hold condition.
- R7: While `ref_valid` is 0 and `suppress` is 0, `lol` is 1 from the next clock edge on. The lock state and the window are cleared.
- R8: While `suppress` is 1, `lol` is 0 from the next edge on, even when the reference is absent. `reacq` stays 0, and the lock state and the window are cleared.
- R9: During and right after reset, `lol` is 1, `reacq` is 0 and the detector is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| rec_tick | input | 1 | One-cycle strobe per recovered clock edge |
| rate_sel | input | 1 | Line-rate select: 0 fast rate, 1 slow rate |
| ref_valid | input | 1 | Reference activity present |
| suppress | input | 1 | Power-down / calibration in progress |
| loss_ppm | input | PPM_W | Loss-of-lock threshold in ppm |
| lol | output | 1 | Loss-of-lock alarm |
| reacq | output | 1 | Reacquisition request pulse |

## Verification
The bench builds the block with WIN_REF=64, HYST_PPM=25000 and REACQ_K=3, and drives a loss limit of 40000 ppm. With a 64-edge window, one count of error equals 15625 ppm. Losing lock therefore needs an error of at least 3 counts, and gaining it needs an exact match. Errors of 1 and 2 counts fall in the hysteresis band and show that the state is held. A reacquisition period of three windows lets several pulses and their run resets appear within a short run. Both rate settings, the reference-absent case and the suppress case are covered in the same sequence.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  localparam logic [63:0] PPM_SCALE = 64'd1000000;

  // absolute difference of two counts
  function automatic logic [31:0] count_err(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // true when err, expressed in ppm of the window, is above the limit
  function automatic logic over_limit(input logic [31:0] err, input logic [31:0] ppm,
                                      input logic [31:0] win);
    logic [63:0] lhs;
    logic [63:0] rhs;
    lhs = 64'(err) * PPM_SCALE;
    rhs = 64'(ppm) * 64'(win);
    return lhs > rhs;
  endfunction

  // lock-gain limit: loss limit less the hysteresis, floored at zero
  function automatic logic [31:0] gain_limit(input logic [31:0] loss, input logic [31:0] hyst);
    return (loss > hyst) ? (loss - hyst) : 32'd0;
  endfunction

endpackage

// File: rtl/rec_divider.sv
module rec_divider #(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic rate_sel,
  input  logic rec_tick,
  output logic div_pulse
);
  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int DW      = $clog2(DIV_MAX + 1);

  logic [DW-1:0] phase_q;
  logic [DW-1:0] ratio;

  assign ratio     = rate_sel ? DW'(DIV_SLOW) : DW'(DIV_FAST);
  assign div_pulse = rec_tick && !hold && (phase_q == ratio - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase_q <= '0;
    else if (hold)         phase_q <= '0;
    else if (div_pulse)    phase_q <= '0;
    else if (rec_tick)     phase_q <= phase_q + DW'(1);
  end

  // R1: the phase never passes the selected ratio
  assert_phase_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && $stable(rate_sel)) |=> (phase_q < ratio));
endmodule

// File: rtl/window_counter.sv
module window_counter #(
  parameter int WIN_REF = 4096,
  parameter int CNT_W   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             ref_tick,
  input  logic             div_pulse,
  output logic             win_close,
  output logic [CNT_W-1:0] rec_total
);
  localparam int RW = (WIN_REF > 1) ? $clog2(WIN_REF) : 1;

  logic [RW-1:0]    ref_cnt_q;
  logic [CNT_W-1:0] rec_cnt_q;

  assign win_close = ref_tick && !hold && (ref_cnt_q == RW'(WIN_REF - 1));
  assign rec_total = (div_pulse && (rec_cnt_q != '1)) ? rec_cnt_q + CNT_W'(1) : rec_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      rec_cnt_q <= '0;
    end else if (hold || win_close) begin
      ref_cnt_q <= '0;
      rec_cnt_q <= '0;
    end else begin
      if (ref_tick) ref_cnt_q <= ref_cnt_q + RW'(1);
      rec_cnt_q <= rec_total;
    end
  end

  // R2: a close is always caused by a reference strobe
  assert_close_on_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |-> (ref_tick && !hold));
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lockdet_pkg::*;
#(
  parameter int WIN_REF  = 4096,
  parameter int CNT_W    = 15,
  parameter int PPM_W    = 20,
  parameter int HYST_PPM = 25,
  parameter int REACQ_K  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             suppress,
  input  logic             ref_valid,
  input  logic             win_close,
  input  logic [CNT_W-1:0] rec_total,
  input  logic [PPM_W-1:0] loss_ppm,
  output logic             lol,
  output logic             reacq
);
  localparam int MW = $clog2(REACQ_K + 1);

  logic          locked_q;
  logic [MW-1:0] miss_q;
  logic          hold;
  logic [31:0]   err;
  logic          drop_lock;
  logic          gain_lock;
  logic          locked_nx;

  assign hold      = suppress || !ref_valid;
  assign err       = count_err(32'(rec_total), 32'(WIN_REF));
  assign drop_lock = over_limit(err, 32'(loss_ppm), 32'(WIN_REF));
  assign gain_lock = !over_limit(err, gain_limit(32'(loss_ppm), 32'(HYST_PPM)), 32'(WIN_REF));
  assign locked_nx = locked_q ? !drop_lock : gain_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      miss_q   <= '0;
      reacq    <= 1'b0;
      lol      <= 1'b1;
    end else begin
      reacq <= 1'b0;
      if (suppress)        lol <= 1'b0;
      else if (!ref_valid) lol <= 1'b1;
      else                 lol <= !locked_q;
      if (hold) begin
        locked_q <= 1'b0;
        miss_q   <= '0;
      end else if (win_close) begin
        locked_q <= locked_nx;
        if (locked_nx) begin
          miss_q <= '0;
        end else if (miss_q == MW'(REACQ_K - 1)) begin
          miss_q <= '0;
          reacq  <= 1'b1;
        end else begin
          miss_q <= miss_q + MW'(1);
        end
      end
    end
  end

  assert_lock_at_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(win_close));
  assert_supp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> !lol);
  assert_noref_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_valid && !suppress) |=> lol);
  assert_reacq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reacq |=> !reacq);
  assert_reacq_not_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !reacq);
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector #(
  parameter int WIN_REF  = 4096,
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 1,
  parameter int PPM_W    = 20,
  parameter int HYST_PPM = 25,
  parameter int REACQ_K  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             rec_tick,
  input  logic             rate_sel,
  input  logic             ref_valid,
  input  logic             suppress,
  input  logic [PPM_W-1:0] loss_ppm,
  output logic             lol,
  output logic             reacq
);
  localparam int CNT_W = $clog2(4 * WIN_REF) + 1;

  logic             hold;
  logic             div_pulse;
  logic             win_close;
  logic [CNT_W-1:0] rec_total;

  assign hold = suppress || !ref_valid;

  rec_divider #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst_n(rst_n), .hold(hold), .rate_sel(rate_sel),
    .rec_tick(rec_tick), .div_pulse(div_pulse));

  window_counter #(.WIN_REF(WIN_REF), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .hold(hold), .ref_tick(ref_tick),
    .div_pulse(div_pulse), .win_close(win_close), .rec_total(rec_total));

  lock_fsm #(.WIN_REF(WIN_REF), .CNT_W(CNT_W), .PPM_W(PPM_W),
             .HYST_PPM(HYST_PPM), .REACQ_K(REACQ_K)) u_fsm (
    .clk(clk), .rst_n(rst_n), .suppress(suppress), .ref_valid(ref_valid),
    .win_close(win_close), .rec_total(rec_total), .loss_ppm(loss_ppm),
    .lol(lol), .reacq(reacq));
endmodule

// File: tb/tb_freq_lock_detector.sv
module tb_freq_lock_detector;
  localparam int WIN  = 64;
  localparam int HYST = 25000;
  localparam int KREQ = 3;
  localparam int LOSS = 40000;
  localparam int SPAN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, rec_tick = 1'b0, rate_sel = 1'b0;
  logic ref_valid = 1'b1, suppress = 1'b0;
  logic [19:0] loss_ppm = 20'(LOSS);
  logic lol, reacq;

  int checks = 0, failures = 0, seen_reacq = 0;
  bit model_locked = 0;
  int model_run = 0;
  typedef struct { bit lol; int pulses; string tag; } exp_t;
  exp_t expq[$];
  event win_end;

  always #10 clk = ~clk;

  freq_lock_detector #(.WIN_REF(WIN), .HYST_PPM(HYST), .REACQ_K(KREQ)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rec_tick(rec_tick),
    .rate_sel(rate_sel), .ref_valid(ref_valid), .suppress(suppress),
    .loss_ppm(loss_ppm), .lol(lol), .reacq(reacq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of one window, pushed as an expected item
  task automatic predict(input int d, input bit rv, input bit sup, input string tag);
    exp_t e;
    longint err;
    e.tag = tag; e.pulses = 0;
    err = (d < 0) ? -d : d;
    if (sup) begin
      model_locked = 0; model_run = 0; e.lol = 0;
    end else if (!rv) begin
      model_locked = 0; model_run = 0; e.lol = 1;
    end else begin
      if (model_locked && err * 1000000 > longint'(LOSS) * WIN) model_locked = 0;
      else if (!model_locked && err * 1000000 <= longint'(LOSS - HYST) * WIN) model_locked = 1;
      if (model_locked) model_run = 0;
      else begin
        model_run++;
        if (model_run == KREQ) begin e.pulses = 1; model_run = 0; end
      end
      e.lol = !model_locked;
    end
    expq.push_back(e);
  endtask

  // driver: one window of WIN reference strobes with (WIN+d)*ratio recovered strobes
  task automatic run_window(input int d, input bit rate, input bit rv, input bit sup,
                            input string tag);
    int n;
    n = (WIN + d) * (rate ? 1 : 4);
    predict(d, rv, sup, tag);
    for (int c = 0; c < WIN * SPAN; c++) begin
      @(negedge clk);
      rate_sel = rate; ref_valid = rv; suppress = sup;
      ref_tick = rv && (c % SPAN == 0);
      rec_tick = (c < n);
    end
    @(negedge clk);
    ref_tick = 1'b0; rec_tick = 1'b0;
    ->win_end;
  endtask

  always @(negedge clk) if (reacq) seen_reacq++;

  // monitor: compare each finished window with the queued expectation
  initial begin
    forever begin
      exp_t e;
      @(win_end);
      if (expq.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty actual=1 expected=0");
      end else begin
        e = expq.pop_front();
        check({e.tag, " lol"}, int'(lol), int'(e.lol));
        check({e.tag, " reacq"}, seen_reacq, e.pulses);
      end
      seen_reacq = 0;
    end
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset lol", int'(lol), 1);
    check("R9 reset reacq", int'(reacq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 post-reset lol", int'(lol), 1);
    // R3 R6: far off frequency, reacquire on third window
    run_window(5, 0, 1, 0, "R6 off1");
    run_window(5, 0, 1, 0, "R6 off2");
    run_window(5, 0, 1, 0, "R6 off3");
    // R1 R4 R5: exact match locks at the fast rate
    run_window(0, 0, 1, 0, "R4 gain");
    run_window(2, 0, 1, 0, "R4 band hold high");
    run_window(-2, 0, 1, 0, "R4 band hold low");
    run_window(-3, 0, 1, 0, "R3 loss slow side");
    run_window(1, 0, 1, 0, "R4 band stay unlocked");
    run_window(0, 0, 1, 0, "R5 relock");
    // R1: slow rate, divider of one
    run_window(0, 1, 1, 0, "R1 slow rate match");
    run_window(3, 1, 1, 0, "R1 slow rate off");
    // R7: missing reference clears the run count
    run_window(0, 0, 0, 0, "R7 ref absent");
    run_window(9, 0, 1, 0, "R7 run restarted 1");
    run_window(9, 0, 1, 0, "R7 run restarted 2");
    run_window(0, 0, 1, 0, "R5 lock again");
    // R8: suppress overrides, state cleared
    run_window(0, 0, 1, 1, "R8 suppress");
    run_window(0, 0, 0, 1, "R8 suppress over absent ref");
    run_window(10, 0, 1, 0, "R8 after suppress 1");
    run_window(10, 0, 1, 0, "R8 after suppress 2");
    run_window(10, 0, 1, 0, "R6 after suppress 3");
    run_window(10, 0, 1, 0, "R6 run again 1");
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule